// File: doc/BRIEF.md
# Endpoint-zero control read handshake controller

This block follows a USB control read transfer on endpoint zero through its stages: the SETUP token, any number of IN data packets, and the closing OUT status packet. For each decoded token delivered by the packet layer it returns ACK or NAK one cycle later. It also keeps three flags for the CPU: setup-received, OUT-received and IN-ready. It counts the bytes the CPU writes into the endpoint buffer and pulses a flush strobe whenever that buffer must be emptied. Serial encoding, CRC and descriptor parsing happen elsewhere.

Host traffic takes precedence over the CPU. When the first status OUT arrives, that token is NAKed and the queued IN data is thrown away. From then on, a CPU clear of IN-ready no longer commits a bank. The host's retry of the status OUT is ACKed and raises both OUT-received and IN-ready. A SETUP token can arrive in any stage. It is always ACKed, wipes the other flags, resets the buffer and restarts the transfer.

The CPU commits a bank by strobing the IN-ready clear. This arms the next IN token. An interrupt line is driven high while any flag is set together with its enable bit.

Top module: `ep0_ctrl_handshake`

## Requirements
- R1: After reset all flags, `hsValid`, `fifoFlush` and `byteCount` are 0, and IN or OUT tokens are NAKed until a SETUP is seen.
- R2: `hsValid` is high for exactly the one cycle after any cycle with a token input high, and low otherwise. `hsAck` = 1 means ACK and 0 means NAK.
- R3: A SETUP is ACKed in every stage and wins over IN or OUT tokens in the same cycle. One cycle later `flagSetup` = 1, `flagOut` = 0, `flagInRdy` = 0 and `byteCount` = 0, and `fifoFlush` pulses. Any armed bank is dropped.
- R4: While `flagSetup` is 1, IN and OUT tokens are NAKed.
- R5: In the setup or data stage, a `cpuClrInRdy` strobe clears `flagInRdy` and arms a bank. An IN is ACKed only when a bank is armed and `flagSetup` is 0. That ACK sets `flagInRdy`, zeroes `byteCount` and disarms. Without an armed bank, the IN is NAKed.
- R6: In the setup or data stage with no bank armed, each `cpuWrStb` adds one to `byteCount`, which stops at BUF_BYTES. Writes made while a bank is armed are not counted.
- R7: The first OUT of the data stage (with `flagSetup` = 0) is the status stage. It is NAKed, pulses `fifoFlush`, zeroes `byteCount` and drops any armed bank. A zero-length OUT also zeroes `byteCount` in any stage.
- R8: After the status stage is detected, `cpuClrInRdy` has no effect: `flagInRdy` keeps its value, no bank is armed and IN stays NAKed. `cpuWrStb` is not counted.
- R9: The next OUT after detection (the retry) is ACKed and sets `flagOut` and `flagInRdy`.
- R10: After the retry is ACKed, IN and OUT tokens are NAKed until the next SETUP.
- R11: `irq` = (`flagSetup` & `intEn[0]`) | (`flagOut` & `intEn[1]`) | (`flagInRdy` & `intEn[2]`).
- R12: A flag that hardware sets in the same cycle the CPU clears it ends up set. Otherwise a CPU clear (`cpuClrSetup`, `cpuClrOut`) zeroes its flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokSetup | input | 1 | SETUP token decoded (one-cycle pulse) |
| tokIn | input | 1 | IN token decoded |
| tokOut | input | 1 | OUT token decoded |
| tokZeroLen | input | 1 | Qualifies `tokOut`: the OUT packet has no data |
| cpuClrSetup | input | 1 | CPU clears setup-received |
| cpuClrOut | input | 1 | CPU clears OUT-received |
| cpuClrInRdy | input | 1 | CPU clears IN-ready and commits the bank |
| cpuWrStb | input | 1 | CPU writes one byte into the endpoint buffer |
| intEn | input | 3 | Interrupt enables: bit0 setup, bit1 OUT, bit2 IN-ready |
| hsValid | output | 1 | Handshake decision valid |
| hsAck | output | 1 | 1 = ACK, 0 = NAK |
| flagSetup | output | 1 | Setup-received flag |
| flagOut | output | 1 | OUT-received flag |
| flagInRdy | output | 1 | IN-ready flag |
| byteCount | output | CNT_W | Bytes queued by the CPU |
| fifoFlush | output | 1 | One-cycle buffer reset |
| irq | output | 1 | Interrupt request |

## Verification
Host tokens and CPU strobes can land in the same cycle. The cases of interest are a SETUP arriving with a `cpuClrSetup`, a status retry arriving with a `cpuClrInRdy`, and a status OUT arriving together with byte writes or a bank commit. Directed steps place these pairs on one clock edge. A constrained-random run also lets them coincide freely. A cycle model in the bench decides, from the requirements, which event wins: hardware sets beat CPU clears, and status detection beats arming. The bench compares the handshake, the flags, the count, the flush and the interrupt on every cycle.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA_IN,
    ST_STAT_FIRST,
    ST_STAT_DONE
  } stage_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic setupEv;    // SETUP accepted
    logic statusDet;  // first status OUT seen
    logic retryAck;   // status OUT retry accepted
    logic inAck;      // IN data packet accepted
    logic zlpEv;      // zero-length OUT observed
    logic inRdyClr;   // CPU IN-ready clear honoured
    logic wrInc;      // CPU byte write honoured
  } ep0Strobe_t;

endpackage

// File: rtl/ep0_hs_ctrl.sv
module ep0_hs_ctrl
  import ep0_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokSetup,
  input  logic       tokIn,
  input  logic       tokOut,
  input  logic       tokZeroLen,
  input  logic       cpuClrInRdy,
  input  logic       cpuWrStb,
  input  logic       flagSetup,
  output ep0Strobe_t strb,
  output logic       hsValid,
  output logic       hsAck
);

  stage_e stage;
  logic   armed;
  logic   dataStage;
  logic   statusStage;

  assign dataStage   = (stage == ST_SETUP) || (stage == ST_DATA_IN);
  assign statusStage = (stage == ST_STAT_FIRST) || (stage == ST_STAT_DONE);

  always_comb begin
    strb           = '0;
    strb.setupEv   = tokSetup;
    strb.statusDet = !tokSetup && tokOut && !flagSetup && dataStage;
    strb.retryAck  = !tokSetup && tokOut && !flagSetup && (stage == ST_STAT_FIRST);
    strb.inAck     = !tokSetup && !tokOut && tokIn && !flagSetup && dataStage && armed;
    strb.zlpEv     = !tokSetup && tokOut && tokZeroLen;
    strb.inRdyClr  = cpuClrInRdy && dataStage;
    strb.wrInc     = cpuWrStb && dataStage && !armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage   <= ST_IDLE;
      armed   <= 1'b0;
      hsValid <= 1'b0;
      hsAck   <= 1'b0;
    end else begin
      hsValid <= tokSetup || tokIn || tokOut;
      hsAck   <= strb.setupEv || strb.retryAck || strb.inAck;
      if (strb.setupEv)        stage <= ST_SETUP;
      else if (strb.statusDet) stage <= ST_STAT_FIRST;
      else if (strb.retryAck)  stage <= ST_STAT_DONE;
      else if (strb.inAck)     stage <= ST_DATA_IN;
      if (strb.setupEv || strb.statusDet) armed <= 1'b0;
      else if (strb.inRdyClr)             armed <= 1'b1;
      else if (strb.inAck)                armed <= 1'b0;
    end
  end

  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rstN)
    tokSetup |=> (hsValid && hsAck)); // R3
  AST_NAK_WHILE_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (flagSetup && !tokSetup && (tokIn || tokOut)) |=> (hsValid && !hsAck)); // R4
  AST_STATUS_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (statusStage && cpuClrInRdy && !tokSetup) |=> !armed); // R8
  AST_HS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(tokSetup || tokIn || tokOut) |=> !hsValid); // R2

endmodule

// File: rtl/ep0_hs_data.sv
module ep0_hs_data
  import ep0_hs_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ep0Strobe_t       strb,
  input  logic             cpuClrSetup,
  input  logic             cpuClrOut,
  input  logic [2:0]       intEn,
  output logic             flagSetup,
  output logic             flagOut,
  output logic             flagInRdy,
  output logic [CNT_W-1:0] byteCount,
  output logic             fifoFlush,
  output logic             irq
);

  localparam int NFLAG = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_BYTES);

  // bit order: 0 setup, 1 OUT, 2 IN-ready
  logic [NFLAG-1:0] flags, setVec, clrVec;

  assign setVec = {strb.retryAck || strb.inAck, strb.retryAck, strb.setupEv};
  assign clrVec = {strb.inRdyClr || strb.setupEv, cpuClrOut || strb.setupEv, cpuClrSetup};

  for (genvar g = 0; g < NFLAG; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)          flags[g] <= 1'b0;
      else if (setVec[g]) flags[g] <= 1'b1;
      else if (clrVec[g]) flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount <= '0;
      fifoFlush <= 1'b0;
    end else begin
      fifoFlush <= strb.setupEv || strb.statusDet;
      if (strb.setupEv || strb.statusDet || strb.inAck || strb.zlpEv)
        byteCount <= '0;
      else if (strb.wrInc && (byteCount < CNT_MAX))
        byteCount <= byteCount + 1'b1;
    end
  end

  assign flagSetup = flags[0];
  assign flagOut   = flags[1];
  assign flagInRdy = flags[2];
  assign irq       = |(flags & intEn);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CNT_MAX); // R6
  AST_RETRY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strb.retryAck |=> (flagOut && flagInRdy)); // R9
  AST_SETUP_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setupEv |=> (flagSetup && !flagOut && !flagInRdy && byteCount == '0 && fifoFlush)); // R3

endmodule

// File: rtl/ep0_ctrl_handshake.sv
module ep0_ctrl_handshake
  import ep0_hs_pkg::*;
#(
  parameter  int BUF_BYTES = 64,
  localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokSetup,
  input  logic             tokIn,
  input  logic             tokOut,
  input  logic             tokZeroLen,
  input  logic             cpuClrSetup,
  input  logic             cpuClrOut,
  input  logic             cpuClrInRdy,
  input  logic             cpuWrStb,
  input  logic [2:0]       intEn,
  output logic             hsValid,
  output logic             hsAck,
  output logic             flagSetup,
  output logic             flagOut,
  output logic             flagInRdy,
  output logic [CNT_W-1:0] byteCount,
  output logic             fifoFlush,
  output logic             irq
);

  ep0Strobe_t strb;

  ep0_hs_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tokSetup    (tokSetup),
    .tokIn       (tokIn),
    .tokOut      (tokOut),
    .tokZeroLen  (tokZeroLen),
    .cpuClrInRdy (cpuClrInRdy),
    .cpuWrStb    (cpuWrStb),
    .flagSetup   (flagSetup),
    .strb        (strb),
    .hsValid     (hsValid),
    .hsAck       (hsAck)
  );

  ep0_hs_data #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cpuClrSetup (cpuClrSetup),
    .cpuClrOut   (cpuClrOut),
    .intEn       (intEn),
    .flagSetup   (flagSetup),
    .flagOut     (flagOut),
    .flagInRdy   (flagInRdy),
    .byteCount   (byteCount),
    .fifoFlush   (fifoFlush),
    .irq         (irq)
  );

endmodule

// File: tb/sim_ep0_ctrl_handshake.sv
`timescale 1ns/100ps
module sim_ep0_ctrl_handshake;

  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokSetup = 0, tokIn = 0, tokOut = 0, tokZeroLen = 0;
  logic cpuClrSetup = 0, cpuClrOut = 0, cpuClrInRdy = 0, cpuWrStb = 0;
  logic [2:0] intEn = 3'b000;
  logic hsValid, hsAck, flagSetup, flagOut, flagInRdy, fifoFlush, irq;
  logic [CW-1:0] byteCount;

  int nTests = 0, nFail = 0;
  bit done = 0;

  // model state: 0 idle, 1 setup, 2 data-in, 3 status-first, 4 status-done
  int mStage = 0, mCnt = 0;
  bit mArmed = 0, mFS = 0, mFO = 0, mFI = 0, mHv = 0, mHa = 0, mFlush = 0;

  always #2.5 clk = ~clk;

  ep0_ctrl_handshake #(.BUF_BYTES(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .tokSetup(tokSetup), .tokIn(tokIn), .tokOut(tokOut),
    .tokZeroLen(tokZeroLen), .cpuClrSetup(cpuClrSetup), .cpuClrOut(cpuClrOut),
    .cpuClrInRdy(cpuClrInRdy), .cpuWrStb(cpuWrStb), .intEn(intEn),
    .hsValid(hsValid), .hsAck(hsAck), .flagSetup(flagSetup), .flagOut(flagOut),
    .flagInRdy(flagInRdy), .byteCount(byteCount), .fifoFlush(fifoFlush), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expIrq();
    return (mFS && intEn[0]) || (mFO && intEn[1]) || (mFI && intEn[2]);
  endfunction

  // advance the model by one clock from the current inputs
  task automatic modelStep();
    bit dStage, detect, retry, inAk, nFS, nFO, nFI, nArm;
    int nCnt, nStage;
    dStage = (mStage == 1) || (mStage == 2);
    detect = !tokSetup && tokOut && !mFS && dStage;
    retry  = !tokSetup && tokOut && !mFS && (mStage == 3);
    inAk   = !tokSetup && !tokOut && tokIn && !mFS && dStage && mArmed;
    nFS = mFS; nFO = mFO; nFI = mFI; nArm = mArmed; nCnt = mCnt; nStage = mStage;
    if (tokSetup) begin
      nFS = 1; nFO = 0; nFI = 0; nArm = 0; nCnt = 0; nStage = 1;
    end else begin
      if (cpuClrSetup) nFS = 0;
      if (retry) begin nFO = 1; nFI = 1; nStage = 4; end
      else if (cpuClrOut) nFO = 0;
      if (inAk) begin nFI = 1; nStage = 2; end
      else if (!retry && cpuClrInRdy && dStage) nFI = 0;
      if (detect) begin nArm = 0; nStage = 3; end
      else if (cpuClrInRdy && dStage) nArm = 1;
      else if (inAk) nArm = 0;
      if (detect || inAk || (tokOut && tokZeroLen)) nCnt = 0;
      else if (cpuWrStb && dStage && !mArmed && mCnt < DEPTH) nCnt = mCnt + 1;
    end
    mHv = tokSetup || tokIn || tokOut;
    mHa = tokSetup || retry || inAk;
    mFlush = tokSetup || detect;
    mFS = nFS; mFO = nFO; mFI = nFI; mArmed = nArm; mCnt = nCnt; mStage = nStage;
  endtask

  task automatic compareAll();
    chk(hsValid === mHv, "R2 hsValid", int'(hsValid), int'(mHv));
    chk(hsAck === mHa, "R5 hsAck", int'(hsAck), int'(mHa));
    chk(flagSetup === mFS, "R12 flagSetup", int'(flagSetup), int'(mFS));
    chk(flagOut === mFO, "R12 flagOut", int'(flagOut), int'(mFO));
    chk(flagInRdy === mFI, "R12 flagInRdy", int'(flagInRdy), int'(mFI));
    chk(int'(byteCount) == mCnt, "R6 byteCount", int'(byteCount), mCnt);
    chk(fifoFlush === mFlush, "R3 fifoFlush", int'(fifoFlush), int'(mFlush));
    chk(irq === expIrq(), "R11 irq", int'(irq), int'(expIrq()));
  endtask

  // drive at the falling edge, let one rising edge pass, compare at the next falling edge
  task automatic tick(input bit s, input bit i, input bit o, input bit z,
                      input bit cs, input bit co, input bit ci, input bit w);
    tokSetup = s; tokIn = i; tokOut = o; tokZeroLen = z;
    cpuClrSetup = cs; cpuClrOut = co; cpuClrInRdy = ci; cpuWrStb = w;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(); tick(0,0,0,0,0,0,0,0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h0e90_1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(flagSetup == 0 && flagOut == 0 && flagInRdy == 0, "R1 flags", int'({flagInRdy, flagOut, flagSetup}), 0);
    chk(byteCount == 0 && hsValid == 0 && fifoFlush == 0, "R1 count/hs", int'(byteCount), 0);
    tick(0,1,0,0,0,0,0,0);
    chk(hsValid && !hsAck, "R1 IN before SETUP NAK", int'(hsAck), 0);

    // R3: SETUP with a simultaneous IN, SETUP wins and is ACKed
    tick(1,1,0,0,0,0,0,0);
    chk(hsAck && flagSetup && fifoFlush, "R3 setup accepted", int'({hsAck, flagSetup, fifoFlush}), 7);
    // R4: data tokens NAKed while setup flag set
    tick(0,1,0,0,0,0,0,1);
    chk(!hsAck, "R4 IN NAK while setup", int'(hsAck), 0);
    tick(0,0,1,0,0,0,0,1);
    chk(!hsAck && flagOut == 0, "R4 OUT NAK while setup", int'(hsAck), 0);
    tick(0,0,0,0,1,0,0,0);
    chk(!flagSetup, "R12 CPU clear of setup", int'(flagSetup), 0);
    // R5: IN without armed bank NAKed
    tick(0,1,0,0,0,0,0,0);
    chk(!hsAck, "R5 IN unarmed NAK", int'(hsAck), 0);
    repeat (3) tick(0,0,0,0,0,0,0,1);
    chk(byteCount == 5, "R6 writes counted", int'(byteCount), 5);
    tick(0,0,0,0,0,0,1,0);
    tick(0,0,0,0,0,0,0,1);
    chk(byteCount == 5, "R6 write ignored while armed", int'(byteCount), 5);
    tick(0,1,0,0,0,0,0,0);
    chk(hsAck && flagInRdy && byteCount == 0, "R5 IN armed ACK", int'({hsAck, flagInRdy}), 3);
    repeat (70) tick(0,0,0,0,0,0,0,1);
    chk(byteCount == DEPTH, "R6 saturation", int'(byteCount), DEPTH);
    // R7: status detection, with a bank commit and write in the same cycle
    tick(0,0,1,0,0,0,1,1);
    chk(!hsAck && fifoFlush && byteCount == 0, "R7 status NAK+flush", int'({hsAck, fifoFlush}), 1);
    tick(0,0,0,0,0,0,1,1);
    chk(byteCount == 0, "R8 write ignored in status", int'(byteCount), 0);
    tick(0,1,0,0,0,0,0,0);
    chk(!hsAck, "R8 no arming after status", int'(hsAck), 0);
    // R9: retry ACK, with IN-ready clear colliding
    intEn = 3'b010;
    tick(0,0,1,1,0,0,1,0);
    chk(hsAck && flagOut && flagInRdy, "R9 retry ACK", int'({hsAck, flagOut, flagInRdy}), 7);
    chk(irq == 1, "R11 irq from OUT flag", int'(irq), 1);
    tick(0,0,0,0,0,0,1,0);
    chk(flagInRdy == 1, "R8 IN-ready clear ignored", int'(flagInRdy), 1);
    // R10: nothing accepted until SETUP
    tick(0,0,1,0,0,0,0,0);
    chk(!hsAck, "R10 OUT NAK after done", int'(hsAck), 0);
    tick(0,1,0,0,0,1,0,0);
    chk(!hsAck && !flagOut && !irq, "R10 IN NAK after done", int'(hsAck), 0);
    // R12: SETUP and setup-clear in one cycle
    tick(1,0,0,0,1,0,0,0);
    chk(flagSetup == 1, "R12 set beats clear", int'(flagSetup), 1);
    idle();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom % 100;
      if ($urandom % 50 == 0) intEn = 3'($urandom);
      tick(k < 4, k >= 4 && k < 22, k >= 22 && k < 32, ($urandom % 2) == 1,
           ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0, ($urandom % 3) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule